// File: doc/BRIEF.md
# Shared L2 Word Registry Bank

This block is one bank of a shared second-level cache whose data array also acts as the coherence directory. Each word is in one of two states. In the Valid state it holds the current data. In the Registered state the same storage holds the ID of the single core that owns the up-to-date copy. No separate directory array, sharer list or invalidation traffic exists. The bank tracks exactly one up-to-date copy per word.

Cores send three kinds of request. A registration claims ownership of a word before that core writes it; the bank acknowledges it on the next cycle. A core must hold that acknowledgement before the next parallel phase begins. A read of a Valid word returns its data. A read of a Registered word returns a forward indication carrying the owner's ID, so the requester can fetch the data from that core. A writeback from the current owner returns the word to Valid with the supplied data. All read responses arrive a fixed number of cycles after the request, whether they carry data or a forward.

Top module: `l2_word_registry`

## Requirements
- R1: After reset every word is Valid and holds zero, `reg_ack` is all zero and `rsp_valid` is low.
- R2: A registration by core i for word a raises `reg_ack[i]` for exactly one cycle, on the cycle after the request. From then on, word a is Registered with owner i.
- R3: A read of a Registered word gives a response with `rsp_fwd` = 1 and `rsp_data` = owner ID, zero-extended. `rsp_core` echoes the requester.
- R4: A writeback from the owner of a Registered word makes the word Valid with the written data. A later read returns that data with `rsp_fwd` = 0.
- R5: A writeback from a core that is not the owner, or to a word that is already Valid, leaves the word unchanged.
- R6: Registrations from several cores for the same word in one cycle are served lowest core ID first, so the highest requesting ID becomes the owner. Every requester is acknowledged. Registrations for different words in the same cycle all take effect.
- R7: `rsp_valid` pulses for one cycle exactly READ_LAT rising edges after the edge that samples `rd_valid`, and not earlier.
- R8: If a registration and an owner writeback hit the same word in one cycle, the registration takes effect. A registration changes no other word. The bank emits nothing besides acknowledgements and read responses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | NCORES | Per-core registration request |
| reg_addr | input | NCORES*AW | Per-core word address, lane i at bits [i*AW +: AW] |
| reg_ack | output | NCORES | Per-core registration acknowledgement |
| wb_valid | input | 1 | Owner writeback request |
| wb_core | input | CW | Core issuing the writeback |
| wb_addr | input | AW | Word written back |
| wb_data | input | DW | Data written back |
| rd_valid | input | 1 | Read request |
| rd_core | input | CW | Core issuing the read |
| rd_addr | input | AW | Word read |
| rsp_valid | output | 1 | Read response valid |
| rsp_fwd | output | 1 | 1: forward to owner, 0: data returned |
| rsp_core | output | CW | Requester of this response |
| rsp_data | output | DW | Word data, or owner ID when forwarding |

## Verification
A wrong state bit or owner field is not visible until the word is read. It then shows READ_LAT cycles later as a wrong `rsp_fwd` flag, or as an owner ID where data was expected, or the reverse. For that reason, every registration, writeback and collision case is followed by a read of the affected word. Reads of a neighbouring word expose a write that went to the wrong address. A dropped or late acknowledgement shows on `reg_ack` one cycle after the request. A wrong pipeline depth shows as `rsp_valid` rising one edge too early or too late.

// File: rtl/l2_word_registry.sv
module l2_word_registry #(
  parameter int NCORES   = 4,
  parameter int WORDS    = 16,
  parameter int DW       = 32,
  parameter int READ_LAT = 2,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCORES-1:0]    reg_valid,
  input  logic [NCORES*AW-1:0] reg_addr,
  output logic [NCORES-1:0]    reg_ack,
  input  logic                 wb_valid,
  input  logic [CW-1:0]        wb_core,
  input  logic [AW-1:0]        wb_addr,
  input  logic [DW-1:0]        wb_data,
  input  logic                 rd_valid,
  input  logic [CW-1:0]        rd_core,
  input  logic [AW-1:0]        rd_addr,
  output logic                 rsp_valid,
  output logic                 rsp_fwd,
  output logic [CW-1:0]        rsp_core,
  output logic [DW-1:0]        rsp_data
);

  logic [DW-1:0] word_q [WORDS];
  logic [WORDS-1:0] owned_q;

  logic          pv_q [READ_LAT];
  logic          pf_q [READ_LAT];
  logic [CW-1:0] pc_q [READ_LAT];
  logic [DW-1:0] pd_q [READ_LAT];

  logic wb_hit;
  assign wb_hit = wb_valid && owned_q[wb_addr] && (word_q[wb_addr] == DW'(wb_core));

  // Writeback first, then registrations in rising core order: the last write wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) word_q[w] <= '0;
      owned_q <= '0;
      reg_ack <= '0;
    end else begin
      reg_ack <= reg_valid;
      if (wb_hit) begin
        word_q[wb_addr]  <= wb_data;
        owned_q[wb_addr] <= 1'b0;
      end
      for (int i = 0; i < NCORES; i++) begin
        if (reg_valid[i]) begin
          word_q[reg_addr[i*AW +: AW]]  <= DW'(i);
          owned_q[reg_addr[i*AW +: AW]] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < READ_LAT; k++) begin
        pv_q[k] <= 1'b0;
        pf_q[k] <= 1'b0;
        pc_q[k] <= '0;
        pd_q[k] <= '0;
      end
    end else begin
      pv_q[0] <= rd_valid;
      pf_q[0] <= owned_q[rd_addr];
      pc_q[0] <= rd_core;
      pd_q[0] <= word_q[rd_addr];
      for (int k = 1; k < READ_LAT; k++) begin
        pv_q[k] <= pv_q[k-1];
        pf_q[k] <= pf_q[k-1];
        pc_q[k] <= pc_q[k-1];
        pd_q[k] <= pd_q[k-1];
      end
    end
  end

  assign rsp_valid = pv_q[READ_LAT-1];
  assign rsp_fwd   = pf_q[READ_LAT-1];
  assign rsp_core  = pc_q[READ_LAT-1];
  assign rsp_data  = pd_q[READ_LAT-1];

  for (genvar i = 0; i < NCORES; i++) begin : g_core_chk
    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid[i] |=> reg_ack[i]);
    assert_no_stray_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_valid[i] |=> !reg_ack[i]);
    assert_word_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid[i] |=> owned_q[$past(reg_addr[i*AW +: AW])]);
  end

  assert_fwd_carries_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fwd) |-> (rsp_data < DW'(NCORES)));

  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_valid, READ_LAT));

endmodule

// File: tb/l2_word_registry_tb_top.sv
module l2_word_registry_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int AWB = 4;
  localparam int DWB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]     reg_valid = '0;
  logic [NC*AWB-1:0] reg_addr = '0;
  logic [NC-1:0]     reg_ack;
  logic              wb_valid = 1'b0;
  logic [1:0]        wb_core = '0;
  logic [AWB-1:0]    wb_addr = '0;
  logic [DWB-1:0]    wb_data = '0;
  logic              rd_valid = 1'b0;
  logic [1:0]        rd_core = '0;
  logic [AWB-1:0]    rd_addr = '0;
  logic              rsp_valid, rsp_fwd;
  logic [1:0]        rsp_core;
  logic [DWB-1:0]    rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  l2_word_registry #(.NCORES(NC), .WORDS(16), .DW(DWB), .READ_LAT(2)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_addr(reg_addr), .reg_ack(reg_ack),
    .wb_valid(wb_valid), .wb_core(wb_core), .wb_addr(wb_addr), .wb_data(wb_data),
    .rd_valid(rd_valid), .rd_core(rd_core), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_fwd(rsp_fwd), .rsp_core(rsp_core), .rsp_data(rsp_data));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(string req, logic [DWB-1:0] act, logic [DWB-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reg(logic [NC-1:0] mask, logic [NC*AWB-1:0] addrs, string req);
    @(negedge clk);
    reg_valid = mask;
    reg_addr  = addrs;
    @(negedge clk);
    check(req, DWB'(reg_ack), DWB'(mask));
    reg_valid = '0;
    @(negedge clk);
    check(req, DWB'(reg_ack), '0);
  endtask

  task automatic do_wb(logic [1:0] core, logic [AWB-1:0] addr, logic [DWB-1:0] data);
    @(negedge clk);
    wb_valid = 1'b1; wb_core = core; wb_addr = addr; wb_data = data;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic do_rd(logic [1:0] core, logic [AWB-1:0] addr, logic efwd,
                       logic [DWB-1:0] edata, string req);
    @(negedge clk);
    rd_valid = 1'b1; rd_core = core; rd_addr = addr;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R7 early", DWB'(rsp_valid), 0);
    @(negedge clk);
    check("R7 valid", DWB'(rsp_valid), 1);
    check(req, DWB'(rsp_fwd), DWB'(efwd));
    check(req, rsp_data, edata);
    check("R3 core", DWB'(rsp_core), DWB'(core));
    @(negedge clk);
    check("R7 pulse", DWB'(rsp_valid), 0);
  endtask

  // op: 0 registration (mask, same word on all lanes), 1 writeback, 2 read
  typedef struct packed {
    logic [1:0]     op;
    logic [NC-1:0]  mask;
    logic [1:0]     core;
    logic [AWB-1:0] addr;
    logic [DWB-1:0] data;
    logic           efwd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 4'b0000, 2'd1, 4'd3, 32'h0000_0000, 1'b0},  // R1 reset word valid zero
    '{2'd0, 4'b0001, 2'd0, 4'd3, 32'h0000_0000, 1'b0},  // R2 core0 registers word3
    '{2'd2, 4'b0000, 2'd2, 4'd3, 32'h0000_0000, 1'b1},  // R3 forward to owner 0
    '{2'd1, 4'b0000, 2'd1, 4'd3, 32'h0000_00aa, 1'b0},  // R5 non-owner writeback
    '{2'd2, 4'b0000, 2'd2, 4'd3, 32'h0000_0000, 1'b1},  // R5 still owned by 0
    '{2'd1, 4'b0000, 2'd0, 4'd3, 32'h0000_1234, 1'b0},  // R4 owner writeback
    '{2'd2, 4'b0000, 2'd1, 4'd3, 32'h0000_1234, 1'b0},  // R4 valid data back
    '{2'd0, 4'b1111, 2'd0, 4'd7, 32'h0000_0000, 1'b0},  // R6 all cores word7
    '{2'd2, 4'b0000, 2'd0, 4'd7, 32'h0000_0003, 1'b1},  // R6 owner is core3
    '{2'd2, 4'b0000, 2'd0, 4'd3, 32'h0000_1234, 1'b0},  // R8 word3 untouched
    '{2'd1, 4'b0000, 2'd3, 4'd7, 32'h0000_0077, 1'b0},  // R4 core3 writeback
    '{2'd2, 4'b0000, 2'd2, 4'd7, 32'h0000_0077, 1'b0}   // R4 valid again
  };

  initial begin
    #(CLK_PERIOD * 2 + 1);
    check("R1 ack", DWB'(reg_ack), 0);
    check("R1 rsp", DWB'(rsp_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack after", DWB'(reg_ack), 0);
    check("R1 rsp after", DWB'(rsp_valid), 0);

    for (int v = 0; v < NV; v++) begin
      case (VEC[v].op)
        2'd0: do_reg(VEC[v].mask, {NC{VEC[v].addr}}, "R2/R6 ack");
        2'd1: do_wb(VEC[v].core, VEC[v].addr, VEC[v].data);
        default: do_rd(VEC[v].core, VEC[v].addr, VEC[v].efwd, VEC[v].data, "vector read");
      endcase
    end

    // R6: different words in one cycle all register
    do_reg(4'b0110, {4'd0, 4'd6, 4'd5, 4'd0}, "R6 ack split");
    do_rd(2'd0, 4'd5, 1'b1, 32'd1, "R6 word5 owner1");
    do_rd(2'd3, 4'd6, 1'b1, 32'd2, "R6 word6 owner2");

    // R8: registration and owner writeback collide on word9
    do_reg(4'b0010, {4'd0, 4'd0, 4'd9, 4'd0}, "R2 word9");
    @(negedge clk);
    wb_valid = 1'b1; wb_core = 2'd1; wb_addr = 4'd9; wb_data = 32'hdead;
    reg_valid = 4'b0100; reg_addr = {4'd0, 4'd9, 4'd0, 4'd0};
    @(negedge clk);
    check("R8 ack", DWB'(reg_ack), 32'h4);
    wb_valid = 1'b0; reg_valid = '0;
    do_rd(2'd0, 4'd9, 1'b1, 32'd2, "R8 registration wins");
    do_wb(2'd2, 4'd9, 32'hbeef);
    do_rd(2'd0, 4'd9, 1'b0, 32'hbeef, "R4 word9 writeback");
    do_wb(2'd0, 4'd9, 32'h5555);
    do_rd(2'd1, 4'd9, 1'b0, 32'hbeef, "R5 writeback to valid word");
    do_rd(2'd1, 4'd4, 1'b0, 32'h0, "R8 neighbour word4 untouched");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule